// File: doc/BRIEF.md
# Comparator-Mode Event Router

This block decides where a peripheral's condition flag, its two edge interrupts and its timer-run control get their input. One bit of the control word picks between two modes. In comparator mode, all of these follow a digital comparator result, which is high when the positive input lies above the negative input. A falling comparator edge starts the timer in hardware and a rising edge stops it. In general I/O mode, the flag and the interrupts follow raw port pins, and the timer runs only while a software enable bit is set.

The pins and the comparator result arrive asynchronously, so each one passes through a synchronizer. The control word and the port direction bits come from registers in the same clock domain and are used as they arrive. The block also raises a warning when comparator mode is on while either comparator pin is still set as an output.

Top module: `cmp_event_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with all inputs low, `cond_flag`, `irq_rise`, `irq_fall`, `timer_run` and `dir_conflict` are all 0. Reset also clears the hardware timer latch.
- R2: `cond_flag` shows the synchronized comparator result when `ctrl_reg[15]` is 1. It shows the synchronized `pin_d1` level when that bit is 0. A change at a pin is visible after two rising clock edges.
- R3: `irq_rise` is a pulse on the rising edge of the comparator result in comparator mode, and on the rising edge of `pin_d4` in I/O mode. It goes high after the third rising clock edge that follows the input change.
- R4: `irq_fall` is a pulse on the falling edge of the comparator result in comparator mode, and on the 1-to-0 change of `pin_d5` in I/O mode. It has the same latency as R3.
- R5: In comparator mode, with `ctrl_reg[9]` at 0, a falling comparator edge sets the timer latch and a rising edge clears it. `timer_run` reflects the latch in the same cycle as the matching interrupt pulse. While `ctrl_reg[9]` is 1, the latch holds its value.
- R6: When `ctrl_reg[9]` is 1, `timer_run` is 1 in either mode, with no clock delay. In I/O mode, `timer_run` equals `ctrl_reg[9]`.
- R7: A change of `ctrl_reg[15]` does not produce an interrupt pulse or a timer event. The timer latch is cleared while comparator mode is off, so entering comparator mode starts with the timer stopped.
- R8: `dir_conflict` is 1 exactly when `ctrl_reg[15]` is 1 and `port_dir[4]` or `port_dir[5]` is 1. It follows these inputs combinationally.
- R9: Each interrupt pulse lasts exactly one clock cycle.
- R10: In comparator mode, changes on `pin_d4` and `pin_d5` have no effect on any output. In I/O mode, comparator edges have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_d1 | input | 1 | Port pin level used for the flag in I/O mode |
| pin_d4 | input | 1 | Port pin level; rising-edge interrupt source in I/O mode |
| pin_d5 | input | 1 | Port pin level; falling-edge interrupt source in I/O mode |
| cmp_hi | input | 1 | Comparator result, 1 when the positive input is above the negative input |
| ctrl_reg | input | 16 | Control word: bit 15 selects comparator mode, bit 9 is the software timer enable |
| port_dir | input | 8 | Port direction bits, 1 = output |
| cond_flag | output | 1 | Condition flag |
| irq_rise | output | 1 | Rising-edge interrupt pulse |
| irq_fall | output | 1 | Falling-edge interrupt pulse |
| timer_run | output | 1 | Timer run request |
| dir_conflict | output | 1 | Comparator pin set as output while comparator mode is on |

## Verification
A change at a pin or at the comparator reaches `cond_flag` two edges later. It reaches the interrupt pulses and the timer latch on the third edge. The bench changes one row of inputs at a falling edge, counts three rising edges, and samples every output at the next falling edge. One cycle later it samples again to confirm that the pulses have ended. `dir_conflict` and the software timer enable are combinational paths, so they are checked a fraction of a cycle after they are driven. Rows that flip the mode leave the pins unchanged, so any pulse seen in those rows would be a false event caused by the switch itself.

// File: rtl/cmp_event_router.sv
module cmp_event_router #(
  parameter int CTRL_W      = 16,
  parameter int MODE_BIT    = 15,
  parameter int SWRUN_BIT   = 9,
  parameter int DIR_W       = 8,
  parameter int NEG_DIR_BIT = 4,
  parameter int POS_DIR_BIT = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_d1,
  input  logic              pin_d4,
  input  logic              pin_d5,
  input  logic              cmp_hi,
  input  logic [CTRL_W-1:0] ctrl_reg,
  input  logic [DIR_W-1:0]  port_dir,
  output logic              cond_flag,
  output logic              irq_rise,
  output logic              irq_fall,
  output logic              timer_run,
  output logic              dir_conflict
);

  localparam int NSIG = 4;
  localparam int LAST = SYNC_STAGES - 1;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic            s_d1, s_d4, s_d5, s_cmp;
  logic            mode, sw_run, mode_q, mode_chg;
  logic            rise_src, fall_src, rise_hist, fall_hist;
  logic            rise_evt, fall_evt, hw_run;

  assign raw = {cmp_hi, pin_d5, pin_d4, pin_d1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {s_cmp, s_d5, s_d4, s_d1} = sync_q[LAST];

  assign mode     = ctrl_reg[MODE_BIT];
  assign sw_run   = ctrl_reg[SWRUN_BIT];
  assign mode_chg = mode ^ mode_q;

  assign rise_src = mode ? s_cmp : s_d4;
  assign fall_src = mode ? s_cmp : s_d5;
  assign rise_evt = ~mode_chg & rise_src & ~rise_hist;
  assign fall_evt = ~mode_chg & ~fall_src & fall_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      rise_hist <= 1'b0;
      fall_hist <= 1'b0;
      irq_rise  <= 1'b0;
      irq_fall  <= 1'b0;
      hw_run    <= 1'b0;
    end else begin
      mode_q    <= mode;
      rise_hist <= rise_src;
      fall_hist <= fall_src;
      irq_rise  <= rise_evt;
      irq_fall  <= fall_evt;
      if (!mode)
        hw_run <= 1'b0;
      else if (!sw_run) begin
        if (fall_evt)      hw_run <= 1'b1;
        else if (rise_evt) hw_run <= 1'b0;
      end
    end
  end

  assign cond_flag    = mode ? s_cmp : s_d1;
  assign timer_run    = sw_run | (mode & hw_run);
  assign dir_conflict = mode & (port_dir[NEG_DIR_BIT] | port_dir[POS_DIR_BIT]);

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> !irq_rise); // R9
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fall |=> !irq_fall); // R9
  AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |=> (!irq_rise && !irq_fall)); // R7
  AST_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> !hw_run); // R7
  AST_HW_START: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fall && $past(mode) && !$past(sw_run)) |-> hw_run); // R5
  AST_HW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rise && $past(mode) && !$past(sw_run)) |-> !hw_run); // R5

endmodule

// File: tb/cmp_event_router_tb.sv
module cmp_event_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_d1 = 1'b0, pin_d4 = 1'b0, pin_d5 = 1'b0, cmp_hi = 1'b0;
  logic [15:0] ctrl_reg = '0;
  logic [7:0]  port_dir = '0;
  logic        cond_flag, irq_rise, irq_fall, timer_run, dir_conflict;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cmp_event_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .pin_d1(pin_d1), .pin_d4(pin_d4), .pin_d5(pin_d5), .cmp_hi(cmp_hi),
    .ctrl_reg(ctrl_reg), .port_dir(port_dir),
    .cond_flag(cond_flag), .irq_rise(irq_rise), .irq_fall(irq_fall),
    .timer_run(timer_run), .dir_conflict(dir_conflict)
  );

  // inputs [12:5]: mode, sw, dir5, dir4, d1, d4, d5, cmp
  // expect [4:0]:  cond, rise, fall, run, conflict
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_0_0_0_1_0_0_0_10000,
    13'b0_0_0_0_0_1_0_0_01000,
    13'b0_0_0_0_0_1_1_0_00000,
    13'b0_0_0_0_0_1_0_0_00100,
    13'b0_0_0_0_0_1_0_1_00000,
    13'b1_0_0_0_0_1_0_1_10000,
    13'b1_0_0_0_0_1_0_0_00110,
    13'b1_0_0_0_0_0_1_0_00010,
    13'b1_0_0_0_0_0_1_1_11000,
    13'b1_0_0_1_0_0_1_1_10001,
    13'b1_0_1_0_0_0_1_1_10001,
    13'b1_0_0_0_0_0_1_0_00110,
    13'b1_1_0_0_0_0_1_1_11010,
    13'b1_0_0_0_0_0_1_1_10010,
    13'b1_0_0_0_0_0_1_0_00110,
    13'b0_0_0_0_0_0_1_0_00000,
    13'b0_0_1_1_1_0_1_0_10000,
    13'b0_1_1_1_1_0_1_0_10010,
    13'b1_0_0_0_1_0_1_0_00000,
    13'b0_0_0_0_1_0_1_0_10000
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cond in reset", cond_flag, 1'b0);
    chk("R1 rise in reset", irq_rise, 1'b0);
    chk("R1 fall in reset", irq_fall, 1'b0);
    chk("R1 run in reset", timer_run, 1'b0);
    chk("R1 conflict in reset", dir_conflict, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after release", cond_flag | irq_rise | irq_fall | timer_run, 1'b0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ctrl_reg[15] = VEC[v][12];
      ctrl_reg[9]  = VEC[v][11];
      port_dir[5]  = VEC[v][10];
      port_dir[4]  = VEC[v][9];
      pin_d1       = VEC[v][8];
      pin_d4       = VEC[v][7];
      pin_d5       = VEC[v][6];
      cmp_hi       = VEC[v][5];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R10 cond row %0d", v), cond_flag, VEC[v][4]);
      chk($sformatf("R3/R7/R10 rise row %0d", v), irq_rise, VEC[v][3]);
      chk($sformatf("R4/R7/R10 fall row %0d", v), irq_fall, VEC[v][2]);
      chk($sformatf("R5/R6/R7 run row %0d", v), timer_run, VEC[v][1]);
      chk($sformatf("R8 conflict row %0d", v), dir_conflict, VEC[v][0]);
      @(negedge clk);
      chk($sformatf("R9 rise ended row %0d", v), irq_rise, 1'b0);
      chk($sformatf("R9 fall ended row %0d", v), irq_fall, 1'b0);
    end

    // R6: software enable acts without clock delay in both modes
    @(negedge clk);
    ctrl_reg[9] = 1'b1;
    #1 chk("R6 sw run io mode", timer_run, 1'b1);
    ctrl_reg[9] = 1'b0;
    #1 chk("R6 sw stop io mode", timer_run, 1'b0);
    ctrl_reg[15] = 1'b1;
    ctrl_reg[9]  = 1'b1;
    #1 chk("R6 sw run cmp mode", timer_run, 1'b1);
    // R8: combinational conflict tracking
    port_dir[5] = 1'b1;
    #1 chk("R8 conflict immediate", dir_conflict, 1'b1);
    ctrl_reg[15] = 1'b0;
    #1 chk("R8 conflict needs mode", dir_conflict, 1'b0);
    port_dir = '0;
    ctrl_reg = '0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule